// File: doc/BRIEF.md
# Dual-Clock Frame-to-Word Width Gearbox

This block connects a wide datapath that moves one 120-bit frame per cycle on a slow clock to a narrow datapath that moves one 40-bit word per cycle on a clock exactly three times faster. Both sides therefore carry the same bit rate. The block has two independent directions. The transmit direction takes frames on the slow clock and emits each one as three consecutive words on the fast clock. The receive direction collects words on the fast clock and delivers whole frames on the slow clock.

Each direction is built around a small frame-wide dual-port storage array. It is written in one clock domain and read in the other. Each domain has its own address controller, and the pointers cross between domains in Gray code through two-stage synchronizers. Because the clock ratio equals the width ratio, neither side needs backpressure. A reader begins only once a small backlog exists and then runs freely. Sticky status flags report a reader that ran dry or a writer that found the store full. One reset input is asserted asynchronously and released synchronously in each domain.

Top module: `width_gearbox_cdc`

## Requirements
- R1: On the transmit side, every frame is sent as three words on consecutive fast-clock cycles: bits [119:80] first, then [79:40], then [39:0]. `tx_word_valid` never drops inside a frame.
- R2: Frames are written on every slow-clock cycle and the fast side runs continuously. Under these conditions the transmit side outputs every frame in arrival order with no gap between words, and neither overflow flag sets.
- R3: On the receive side, the first word of each group of three lands in frame bits [119:80], the second in [79:40] and the third in [39:0]. Fast-clock cycles with `rx_word_valid` low are skipped and do not break a group.
- R4: With words arriving on every fast-clock cycle, the receive side outputs every frame in order, on consecutive slow-clock cycles.
- R5: A reader stays idle while fewer than two frames are stored. A single stored frame produces no output.
- R6: Once started, a reader drains the store. If it needs a frame and the store is empty, its underflow flag sets and stays set until reset, and the reader goes back to waiting for two frames.
- R7: A write that finds all 8 entries occupied is dropped and sets that direction's overflow flag, which stays set until reset. The frames already stored are still delivered intact and in order.
- R8: While reset is high, all valid outputs and status flags are 0. Reset also clears both pointers of each store, so a frame written before reset is never delivered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst | input | 1 | Reset, active high, asserted asynchronously |
| clk_wide | input | 1 | Slow clock for the 120-bit frame side |
| clk_narrow | input | 1 | Fast clock for the 40-bit word side, three times clk_wide |
| tx_frame_valid | input | 1 | A transmit frame is present this slow cycle |
| tx_frame | input | 120 | Transmit frame |
| tx_overflow | output | 1 | Sticky: a transmit frame was dropped (slow domain) |
| tx_word_valid | output | 1 | A transmit word is present this fast cycle |
| tx_word | output | 40 | Transmit word |
| tx_underflow | output | 1 | Sticky: transmit reader found the store empty (fast domain) |
| rx_word_valid | input | 1 | A receive word is present this fast cycle |
| rx_word | input | 40 | Receive word |
| rx_overflow | output | 1 | Sticky: a receive frame was dropped (fast domain) |
| rx_frame_valid | output | 1 | A receive frame is present this slow cycle |
| rx_frame | output | 120 | Receive frame |
| rx_underflow | output | 1 | Sticky: receive reader found the store empty (slow domain) |

## Verification
Several properties are checked on every clock edge. Transmit words come in unbroken groups of three. Each pointer changes by at most one bit per cycle on its way across domains. All four status flags stay set once they rise. The bench scenarios cover the rest. They compare word order and frame packing against a scoreboard, and measure that a matched-rate stream runs without gaps. They also show that the two-frame start threshold, the drain-then-underflow sequence, the dropping of writes when the store is full (done by stopping the other clock), and the pointer clearing on reset behave as required at the ports.

// File: rtl/gb_pkg.sv
package gb_pkg;

    localparam int GB_WORD_W   = 40;
    localparam int GB_RATIO    = 3;
    localparam int GB_DEPTH    = 8;
    localparam int GB_START    = 2;

    typedef enum logic {
        RD_PRIME  = 1'b0,
        RD_STREAM = 1'b1
    } rd_state_t;

endpackage

// File: rtl/gb_rst_sync.sv
module gb_rst_sync (
    input  logic clk,
    input  logic rst_async,
    output logic rst_sync
);
    logic [1:0] stage;

    always_ff @(posedge clk or posedge rst_async) begin
        if (rst_async) stage <= 2'b11;
        else           stage <= {stage[0], 1'b0};
    end

    assign rst_sync = stage[1];
endmodule

// File: rtl/gb_sync.sv
module gb_sync #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta <= '0;
            q    <= '0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/gb_fifo.sv
module gb_fifo
    import gb_pkg::*;
#(
    parameter int DATA_W    = 120,
    parameter int DEPTH     = 8,
    parameter int START_LVL = 2,
    localparam int AW       = $clog2(DEPTH),
    localparam int PW       = AW + 1
) (
    input  logic              wr_clk,
    input  logic              wr_rst,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic              wr_overflow,
    output logic [PW-1:0]     wr_gray,
    input  logic              rd_clk,
    input  logic              rd_rst,
    input  logic              rd_req,
    output logic              rd_ok,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_underflow,
    output logic [PW-1:0]     rd_gray
);
    logic [DATA_W-1:0] mem [DEPTH];

    // write domain
    logic [PW-1:0] wbin, wnext, rgray_s, rbin_s;
    logic          wfull, wr_fire;

    gb_sync #(.W(PW)) u_sync_r2w (
        .clk(wr_clk), .rst(wr_rst), .d(rd_gray), .q(rgray_s)
    );

    always_comb begin
        for (int i = 0; i < PW; i++) rbin_s[i] = ^(rgray_s >> i);
    end

    assign wnext   = wbin + 1'b1;
    assign wfull   = (wbin - rbin_s) == PW'(DEPTH);
    assign wr_fire = wr_en && !wfull && !wr_rst;

    always_ff @(posedge wr_clk) begin
        if (wr_rst) begin
            wbin        <= '0;
            wr_gray     <= '0;
            wr_overflow <= 1'b0;
        end else if (wr_en) begin
            if (wfull) begin
                wr_overflow <= 1'b1;
            end else begin
                wbin    <= wnext;
                wr_gray <= wnext ^ (wnext >> 1);
            end
        end
    end

    always_ff @(posedge wr_clk) begin
        if (wr_fire) mem[wbin[AW-1:0]] <= wr_data;
    end

    // read domain
    logic [PW-1:0] rbin, rnext, wgray_s, wbin_s, level;
    rd_state_t     state;

    gb_sync #(.W(PW)) u_sync_w2r (
        .clk(rd_clk), .rst(rd_rst), .d(wr_gray), .q(wgray_s)
    );

    always_comb begin
        for (int i = 0; i < PW; i++) wbin_s[i] = ^(wgray_s >> i);
    end

    assign level   = wbin_s - rbin;
    assign rnext   = rbin + 1'b1;
    assign rd_ok   = (state == RD_STREAM) && rd_req && (level != '0);
    assign rd_data = mem[rbin[AW-1:0]];

    always_ff @(posedge rd_clk) begin
        if (rd_rst) begin
            rbin         <= '0;
            rd_gray      <= '0;
            rd_underflow <= 1'b0;
            state        <= RD_PRIME;
        end else begin
            case (state)
                RD_PRIME: begin
                    if (level >= PW'(START_LVL)) state <= RD_STREAM;
                end
                default: begin
                    if (rd_req) begin
                        if (level != '0) begin
                            rbin    <= rnext;
                            rd_gray <= rnext ^ (rnext >> 1);
                        end else begin
                            rd_underflow <= 1'b1;
                            state        <= RD_PRIME;
                        end
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/width_gearbox_cdc.sv
module width_gearbox_cdc
    import gb_pkg::*;
#(
    parameter int WORD_W    = GB_WORD_W,
    parameter int RATIO     = GB_RATIO,
    parameter int DEPTH     = GB_DEPTH,
    parameter int START_LVL = GB_START
) (
    input  logic                      rst,
    input  logic                      clk_wide,
    input  logic                      clk_narrow,
    input  logic                      tx_frame_valid,
    input  logic [WORD_W*RATIO-1:0]   tx_frame,
    output logic                      tx_overflow,
    output logic                      tx_word_valid,
    output logic [WORD_W-1:0]         tx_word,
    output logic                      tx_underflow,
    input  logic                      rx_word_valid,
    input  logic [WORD_W-1:0]         rx_word,
    output logic                      rx_overflow,
    output logic                      rx_frame_valid,
    output logic [WORD_W*RATIO-1:0]   rx_frame,
    output logic                      rx_underflow
);
    localparam int FRAME_W = WORD_W * RATIO;
    localparam int ACC_W   = FRAME_W - WORD_W;
    localparam int IW      = $clog2(RATIO);
    localparam int PW      = $clog2(DEPTH) + 1;

    logic rst_w, rst_n;

    gb_rst_sync u_rst_wide   (.clk(clk_wide),   .rst_async(rst), .rst_sync(rst_w));
    gb_rst_sync u_rst_narrow (.clk(clk_narrow), .rst_async(rst), .rst_sync(rst_n));

    // transmit: frames in (wide) -> words out (narrow)
    logic               tx_rd_req, tx_rd_ok;
    logic [FRAME_W-1:0] tx_rd_data, tx_shreg;
    logic [PW-1:0]      tx_wr_gray, tx_rd_gray;
    logic [IW-1:0]      tx_idx;

    gb_fifo #(.DATA_W(FRAME_W), .DEPTH(DEPTH), .START_LVL(START_LVL)) u_tx_fifo (
        .wr_clk(clk_wide),   .wr_rst(rst_w), .wr_en(tx_frame_valid), .wr_data(tx_frame),
        .wr_overflow(tx_overflow), .wr_gray(tx_wr_gray),
        .rd_clk(clk_narrow), .rd_rst(rst_n), .rd_req(tx_rd_req), .rd_ok(tx_rd_ok),
        .rd_data(tx_rd_data), .rd_underflow(tx_underflow), .rd_gray(tx_rd_gray)
    );

    assign tx_rd_req = (tx_idx == '0);

    always_ff @(posedge clk_narrow) begin
        if (rst_n) begin
            tx_idx        <= '0;
            tx_shreg      <= '0;
            tx_word       <= '0;
            tx_word_valid <= 1'b0;
        end else begin
            tx_word_valid <= 1'b0;
            if (tx_idx == '0) begin
                if (tx_rd_ok) begin
                    tx_word       <= tx_rd_data[FRAME_W-1 -: WORD_W];
                    tx_shreg      <= tx_rd_data << WORD_W;
                    tx_word_valid <= 1'b1;
                    tx_idx        <= IW'(1);
                end
            end else begin
                tx_word       <= tx_shreg[FRAME_W-1 -: WORD_W];
                tx_shreg      <= tx_shreg << WORD_W;
                tx_word_valid <= 1'b1;
                tx_idx        <= (tx_idx == IW'(RATIO-1)) ? '0 : tx_idx + 1'b1;
            end
        end
    end

    // receive: words in (narrow) -> frames out (wide)
    logic               rx_wr_en, rx_rd_ok;
    logic [FRAME_W-1:0] rx_acc_next, rx_rd_data;
    logic [ACC_W-1:0]   rx_acc;
    logic [IW-1:0]      rx_cnt;
    logic [PW-1:0]      rx_wr_gray, rx_rd_gray;

    assign rx_acc_next = {rx_acc, rx_word};
    assign rx_wr_en    = rx_word_valid && (rx_cnt == IW'(RATIO-1));

    always_ff @(posedge clk_narrow) begin
        if (rst_n) begin
            rx_acc <= '0;
            rx_cnt <= '0;
        end else if (rx_word_valid) begin
            rx_acc <= rx_acc_next[ACC_W-1:0];
            rx_cnt <= (rx_cnt == IW'(RATIO-1)) ? '0 : rx_cnt + 1'b1;
        end
    end

    gb_fifo #(.DATA_W(FRAME_W), .DEPTH(DEPTH), .START_LVL(START_LVL)) u_rx_fifo (
        .wr_clk(clk_narrow), .wr_rst(rst_n), .wr_en(rx_wr_en), .wr_data(rx_acc_next),
        .wr_overflow(rx_overflow), .wr_gray(rx_wr_gray),
        .rd_clk(clk_wide),   .rd_rst(rst_w), .rd_req(1'b1), .rd_ok(rx_rd_ok),
        .rd_data(rx_rd_data), .rd_underflow(rx_underflow), .rd_gray(rx_rd_gray)
    );

    always_ff @(posedge clk_wide) begin
        if (rst_w) begin
            rx_frame_valid <= 1'b0;
            rx_frame       <= '0;
        end else begin
            rx_frame_valid <= rx_rd_ok;
            if (rx_rd_ok) rx_frame <= rx_rd_data;
        end
    end
endmodule

// File: rtl/gb_checker.sv
module gb_checker #(
    parameter int RATIO = 3,
    parameter int PW    = 4
) (
    input logic          clk_wide,
    input logic          clk_narrow,
    input logic          rst_w,
    input logic          rst_n,
    input logic          tx_word_valid,
    input logic          tx_overflow,
    input logic          tx_underflow,
    input logic          rx_overflow,
    input logic          rx_underflow,
    input logic [PW-1:0] tx_wgray,
    input logic [PW-1:0] tx_rgray,
    input logic [PW-1:0] rx_wgray,
    input logic [PW-1:0] rx_rgray
);
    int unsigned wcnt;

    always_ff @(posedge clk_narrow) begin
        if (rst_n)              wcnt <= 0;
        else if (tx_word_valid) wcnt <= (wcnt == RATIO - 1) ? 0 : wcnt + 1;
    end

    a_r1_words_in_threes: assert property (@(posedge clk_narrow) disable iff (rst_n)
        !tx_word_valid |-> wcnt == 0);

    a_r2_tx_wgray_step: assert property (@(posedge clk_wide) disable iff (rst_w)
        $countones(tx_wgray ^ $past(tx_wgray)) <= 1);
    a_r2_tx_rgray_step: assert property (@(posedge clk_narrow) disable iff (rst_n)
        $countones(tx_rgray ^ $past(tx_rgray)) <= 1);
    a_r2_rx_wgray_step: assert property (@(posedge clk_narrow) disable iff (rst_n)
        $countones(rx_wgray ^ $past(rx_wgray)) <= 1);
    a_r2_rx_rgray_step: assert property (@(posedge clk_wide) disable iff (rst_w)
        $countones(rx_rgray ^ $past(rx_rgray)) <= 1);

    a_r6_tx_underflow_sticky: assert property (@(posedge clk_narrow) disable iff (rst_n)
        tx_underflow |=> tx_underflow);
    a_r6_rx_underflow_sticky: assert property (@(posedge clk_wide) disable iff (rst_w)
        rx_underflow |=> rx_underflow);

    a_r7_tx_overflow_sticky: assert property (@(posedge clk_wide) disable iff (rst_w)
        tx_overflow |=> tx_overflow);
    a_r7_rx_overflow_sticky: assert property (@(posedge clk_narrow) disable iff (rst_n)
        rx_overflow |=> rx_overflow);
endmodule

bind width_gearbox_cdc gb_checker #(.RATIO(RATIO), .PW(PW)) u_gb_checker (
    .clk_wide(clk_wide), .clk_narrow(clk_narrow), .rst_w(rst_w), .rst_n(rst_n),
    .tx_word_valid(tx_word_valid), .tx_overflow(tx_overflow), .tx_underflow(tx_underflow),
    .rx_overflow(rx_overflow), .rx_underflow(rx_underflow),
    .tx_wgray(tx_wr_gray), .tx_rgray(tx_rd_gray), .rx_wgray(rx_wr_gray), .rx_rgray(rx_rd_gray)
);

// File: tb/tb_width_gearbox_cdc.sv
`timescale 1ns/1ps
module tb_width_gearbox_cdc;
    localparam int W  = 40;
    localparam int FW = 120;

    logic          rst = 1'b1;
    logic          clk_wide = 1'b0, clk_narrow = 1'b0;
    logic          nrun = 1'b1, wrun = 1'b1;
    logic          tx_frame_valid = 1'b0;
    logic [FW-1:0] tx_frame = '0;
    logic          tx_overflow, tx_word_valid, tx_underflow;
    logic [W-1:0]  tx_word;
    logic          rx_word_valid = 1'b0;
    logic [W-1:0]  rx_word = '0;
    logic          rx_overflow, rx_frame_valid, rx_underflow;
    logic [FW-1:0] rx_frame;

    width_gearbox_cdc dut (
        .rst(rst), .clk_wide(clk_wide), .clk_narrow(clk_narrow),
        .tx_frame_valid(tx_frame_valid), .tx_frame(tx_frame), .tx_overflow(tx_overflow),
        .tx_word_valid(tx_word_valid), .tx_word(tx_word), .tx_underflow(tx_underflow),
        .rx_word_valid(rx_word_valid), .rx_word(rx_word), .rx_overflow(rx_overflow),
        .rx_frame_valid(rx_frame_valid), .rx_frame(rx_frame), .rx_underflow(rx_underflow)
    );

    // 200 MHz fast clock, slow clock at one third, offset by 1 ns
    initial forever begin #2.5 clk_narrow = nrun ? ~clk_narrow : 1'b0; end
    initial begin #1; forever begin #7.5 clk_wide = wrun ? ~clk_wide : 1'b0; end end

    int checks = 0, errors = 0;
    bit done = 0;
    logic [W-1:0]  txq [$];
    logic [FW-1:0] rxq [$];
    int words_seen = 0, frames_seen = 0;
    int ncyc = 0, wcyc = 0;
    int tx_first = -1, tx_last = -1, rx_first = -1, rx_last = -1;

    task automatic chk(input bit ok, input string req, input logic [FW-1:0] act, input logic [FW-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_sim();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    always @(posedge clk_narrow) ncyc++;
    always @(posedge clk_wide)   wcyc++;

    // monitors
    always @(negedge clk_narrow) begin
        if (tx_word_valid) begin
            words_seen++;
            if (tx_first < 0) tx_first = ncyc;
            tx_last = ncyc;
            if (txq.size() == 0) chk(0, "R1 unexpected word", FW'(tx_word), '0);
            else begin
                logic [W-1:0] e;
                e = txq.pop_front();
                chk(tx_word == e, "R1 word order", FW'(tx_word), FW'(e));
            end
        end
    end

    always @(negedge clk_wide) begin
        if (rx_frame_valid) begin
            frames_seen++;
            if (rx_first < 0) rx_first = wcyc;
            rx_last = wcyc;
            if (rxq.size() == 0) chk(0, "R3 unexpected frame", rx_frame, '0);
            else begin
                logic [FW-1:0] e;
                e = rxq.pop_front();
                chk(rx_frame == e, "R3 frame packing", rx_frame, e);
            end
        end
    end

    // drivers
    task automatic send_tx(input int n, input int keep);
        for (int i = 0; i < n; i++) begin
            logic [127:0] r;
            r = {$urandom, $urandom, $urandom, $urandom};
            @(negedge clk_wide);
            tx_frame_valid = 1'b1;
            tx_frame = r[FW-1:0];
            if (i < keep) begin
                txq.push_back(r[119:80]);
                txq.push_back(r[79:40]);
                txq.push_back(r[39:0]);
            end
        end
        @(negedge clk_wide);
        tx_frame_valid = 1'b0;
    endtask

    task automatic send_rx(input int n, input int gap, input int keep);
        for (int i = 0; i < n; i++) begin
            logic [127:0] r;
            r = {$urandom, $urandom, $urandom, $urandom};
            if (i < keep) rxq.push_back(r[FW-1:0]);
            for (int k = 0; k < 3; k++) begin
                @(negedge clk_narrow);
                rx_word_valid = 1'b1;
                rx_word = r[FW-1-k*W -: W];
                for (int g = 0; g < gap; g++) begin
                    @(negedge clk_narrow);
                    rx_word_valid = 1'b0;
                    rx_word = '1;
                end
            end
        end
        @(negedge clk_narrow);
        rx_word_valid = 1'b0;
    endtask

    task automatic clear_marks();
        words_seen = 0; frames_seen = 0;
        tx_first = -1; tx_last = -1; rx_first = -1; rx_last = -1;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (4) @(negedge clk_wide);
        txq.delete(); rxq.delete();
        clear_marks();
        rst = 1'b0;
        repeat (6) @(negedge clk_wide);
    endtask

    initial begin
        #1_000_000;
        checks++; errors++;
        $display("FAIL watchdog expired");
        finish_sim();
    end

    initial begin
        // R8: reset state
        repeat (6) @(negedge clk_wide);
        chk(tx_word_valid == 0 && rx_frame_valid == 0, "R8 valids in reset", FW'({tx_word_valid, rx_frame_valid}), '0);
        chk({tx_overflow, tx_underflow, rx_overflow, rx_underflow} == 0, "R8 flags in reset",
            FW'({tx_overflow, tx_underflow, rx_overflow, rx_underflow}), '0);
        do_reset();

        // R5: one frame is not enough to start
        send_tx(1, 1);
        repeat (40) @(negedge clk_narrow);
        chk(words_seen == 0, "R5 idle with one frame", FW'(words_seen), '0);
        chk(tx_underflow == 0, "R5 no underflow while waiting", FW'(tx_underflow), '0);
        send_tx(1, 1);
        repeat (60) @(negedge clk_narrow);
        chk(words_seen == 6, "R5 starts at two frames", FW'(words_seen), FW'(6));
        chk(txq.size() == 0, "R1 all words delivered", FW'(txq.size()), '0);
        chk(tx_underflow == 1, "R6 underflow after drain", FW'(tx_underflow), FW'(1));

        // R8: reset clears pointers so an earlier frame is lost
        send_tx(1, 0);
        repeat (3) @(negedge clk_wide);
        do_reset();
        chk(tx_underflow == 0, "R8 flag cleared", FW'(tx_underflow), '0);
        send_tx(1, 1);
        repeat (40) @(negedge clk_narrow);
        chk(words_seen == 0, "R8 stale frame cleared", FW'(words_seen), '0);
        send_tx(1, 1);
        repeat (60) @(negedge clk_narrow);
        chk(words_seen == 6, "R8 fresh frames only", FW'(words_seen), FW'(6));

        // R2 / R4: matched-rate streams in both directions
        do_reset();
        fork
            send_tx(20, 20);
            send_rx(20, 0, 20);
        join
        repeat (120) @(negedge clk_narrow);
        chk(words_seen == 60 && txq.size() == 0, "R2 all tx words", FW'(words_seen), FW'(60));
        chk(tx_last - tx_first + 1 == 60, "R2 gapless tx stream", FW'(tx_last - tx_first + 1), FW'(60));
        chk(frames_seen == 20 && rxq.size() == 0, "R4 all rx frames", FW'(frames_seen), FW'(20));
        chk(rx_last - rx_first + 1 == 20, "R4 consecutive rx frames", FW'(rx_last - rx_first + 1), FW'(20));
        chk(tx_overflow == 0 && rx_overflow == 0, "R2 no overflow", FW'({tx_overflow, rx_overflow}), '0);
        chk(rx_underflow == 1, "R6 rx underflow after drain", FW'(rx_underflow), FW'(1));

        // R3: idle cycles between words
        do_reset();
        send_rx(6, 2, 6);
        send_rx(6, 0, 6);
        repeat (60) @(negedge clk_wide);
        chk(frames_seen == 12 && rxq.size() == 0, "R3 gapped words packed", FW'(frames_seen), FW'(12));

        // R7: transmit overflow with the fast clock halted
        rst = 1'b1;
        repeat (4) @(negedge clk_wide);
        txq.delete(); rxq.delete(); clear_marks();
        nrun = 1'b0;
        repeat (2) @(negedge clk_wide);
        rst = 1'b0;
        repeat (6) @(negedge clk_wide);
        send_tx(10, 8);
        repeat (4) @(negedge clk_wide);
        chk(tx_overflow == 1, "R7 tx overflow flag", FW'(tx_overflow), FW'(1));
        chk(words_seen == 0, "R7 nothing read while halted", FW'(words_seen), '0);
        nrun = 1'b1;
        repeat (120) @(negedge clk_narrow);
        chk(words_seen == 24 && txq.size() == 0, "R7 stored tx frames kept", FW'(words_seen), FW'(24));

        // R7: receive overflow with the slow clock halted
        rst = 1'b1;
        repeat (4) @(negedge clk_wide);
        txq.delete(); rxq.delete(); clear_marks();
        wrun = 1'b0;
        repeat (6) @(negedge clk_narrow);
        rst = 1'b0;
        repeat (10) @(negedge clk_narrow);
        send_rx(10, 0, 8);
        repeat (4) @(negedge clk_narrow);
        chk(rx_overflow == 1, "R7 rx overflow flag", FW'(rx_overflow), FW'(1));
        chk(frames_seen == 0, "R7 nothing read while halted", FW'(frames_seen), '0);
        wrun = 1'b1;
        repeat (40) @(negedge clk_wide);
        chk(frames_seen == 8 && rxq.size() == 0, "R7 stored rx frames kept", FW'(frames_seen), FW'(8));

        finish_sim();
    end
endmodule